// File: doc/BRIEF.md
# Paired Counter Snapshot Unit for Reciprocal Frequency Measurement

This block runs two counters side by side. One counts events and the other counts elapsed time. Each counter can step on every system clock or on one chosen edge (rising or falling) of a chosen input pin. When capture is armed, the next qualifying edge on a chosen reference pin copies both counter values into a pair of snapshot registers in one cycle. A capture-ready flag reports that a snapshot has landed.

The counters are never cleared by capture or by reading, so consecutive snapshots give gapless deltas of events and time. Software forms the ratio of those deltas to get a frequency. Software has two ways to take a reading. It can disarm capture, read the pair and re-arm, which rounds down to whole cycles. Or it can arm, wait for the flag, then disarm, which rounds up. Arming and disarming is a single bit in one control write, so it reaches both counters at once.

All pins pass through a two-flop synchronizer before edge detection. Counters are `CNT_W` bits wide, 32 by default, and wrap modulo 2^CNT_W.

Top module: `recip_capture_unit`

## Requirements
- R1: After reset, the control register, both snapshot registers and the capture-ready flag read as zero.
- R2: A counter whose source bit is 0 advances by one on every system clock. With both counters on the system clock from reset, a snapshot holds equal event and time values.
- R3: A counter whose source bit is 1 advances once per detected edge of its selected synchronized pin. The edge is rising when its sense bit is 0 and falling when it is 1. Edges on pins that are not selected do not move it.
- R4: While capture is armed, a detected edge on the reference pin copies both counters into the snapshot pair in the same cycle. The edge is rising when the reference sense bit is 0 and falling when it is 1. The copied values are the counts held in the cycle the edge is detected, before that cycle's increment.
- R5: Neither capture nor reading clears a counter, so event and time deltas across consecutive snapshots lose no edges.
- R6: The capture-ready flag sets on a capture. It clears when software reads address 2 or address 3. If a capture and a clearing read fall in the same cycle, the flag stays set.
- R7: While capture is disarmed, reference edges leave the snapshot pair and the capture-ready flag unchanged.
- R8: While capture stays armed, each new reference edge overwrites the snapshot pair, and the capture-ready flag stays set.
- R9: Counters wrap from all ones to zero, so the unsigned difference of two snapshots modulo 2^CNT_W is the elapsed count.
- R10: The register map is: address 0 control (read/write), address 1 status (bit 0 = capture-ready), address 2 event snapshot, address 3 time snapshot. Control bits are: bit 0 arm, bit 1 event source pin, bit 2 event falling, bit 3 time source pin, bit 4 time falling, bit 5 reference falling, bits 8+ event pin select, bits 16+ time pin select, bits 24+ reference pin select. Each select is SEL_W bits wide. Unused control bits read as zero.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins_in | input | NUM_PINS | Asynchronous input pins |
| csr_we | input | 1 | Register write strobe |
| csr_re | input | 1 | Register read strobe (snapshot reads clear the flag) |
| csr_addr | input | 2 | Register address |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for csr_addr (combinational) |
| cap_ready | output | 1 | Capture-ready flag |

## Verification
The bench sources the event counter from a pin and sends known edge counts between two reference edges. The count must match exactly, which would catch a counter that was cleared on read or on capture, or that counted the wrong edge sense. That includes an extra unpaired rising edge that only a falling-sense counter must ignore. A reference spacing of more than 2^CNT_W cycles on a narrow build exposes wrap handling, and a falling-sense reference pulse held high shows whether capture fires early on the wrong edge. Snapshots taken after disarming, and a double edge without a read in between, show a unit that latches while disarmed or keeps a stale pair instead of the newest one.

// File: rtl/rcu_pkg.sv
package rcu_pkg;
  localparam int CSR_W = 32;

  // control field bit positions
  localparam int CB_ARM     = 0;
  localparam int CB_EV_PIN  = 1;
  localparam int CB_EV_FALL = 2;
  localparam int CB_TM_PIN  = 3;
  localparam int CB_TM_FALL = 4;
  localparam int CB_RF_FALL = 5;
  localparam int CB_EV_SEL  = 8;
  localparam int CB_TM_SEL  = 16;
  localparam int CB_RF_SEL  = 24;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_STAT   = 2'd1,
    REG_SNAP_E = 2'd2,
    REG_SNAP_T = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [7:0] rf_sel;
    logic [7:0] tm_sel;
    logic [7:0] ev_sel;
    logic [1:0] zero;
    logic       rf_fall;
    logic       tm_fall;
    logic       tm_pin;
    logic       ev_fall;
    logic       ev_pin;
    logic       arm;
  } ctrl_view_t;

  function automatic logic pick_edge(input logic rise, input logic fall,
                                     input logic fall_sel);
    return fall_sel ? fall : rise;
  endfunction
endpackage

// File: rtl/rcu_pin_sync.sv
module rcu_pin_sync #(
  parameter int NUM_PINS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_in,
  output logic [NUM_PINS-1:0] rise,
  output logic [NUM_PINS-1:0] fall
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic s1, s2, s3;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        s3 <= 1'b0;
      end else begin
        s1 <= pins_in[i];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign rise[i] = s2 & ~s3;
    assign fall[i] = ~s2 & s3;

    // R3: a detected edge lasts exactly one cycle
    a_r3_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
      rise[i] |=> !rise[i]);
    a_r3_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
      fall[i] |=> !fall[i]);
  end
endmodule

// File: rtl/rcu_counter.sv
module rcu_counter #(
  parameter int CNT_W    = 32,
  parameter int NUM_PINS = 4,
  parameter int SEL_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] rise,
  input  logic [NUM_PINS-1:0] fall,
  input  logic                src_pin,
  input  logic                fall_sel,
  input  logic [SEL_W-1:0]    pin_sel,
  output logic                tick,
  output logic [CNT_W-1:0]    count
);
  import rcu_pkg::*;

  function automatic logic [CNT_W-1:0] wrap_inc(input logic [CNT_W-1:0] v);
    return v + 1'b1;
  endfunction

  logic pin_hit;
  assign pin_hit = pick_edge(rise[pin_sel], fall[pin_sel], fall_sel);
  assign tick    = src_pin ? pin_hit : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else if (tick) count <= wrap_inc(count);
  end

  // R2: system clock source steps every cycle
  a_r2_free_run: assert property (@(posedge clk) disable iff (!rst_n)
    !src_pin |=> count == wrap_inc($past(count)));
  // R3: pin source holds when its selected edge is absent
  a_r3_pin_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (src_pin && !pin_hit) |=> $stable(count));
  // R9: wrap from all ones to zero
  a_r9_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count == {CNT_W{1'b1}}) |=> count == '0);
endmodule

// File: rtl/rcu_snapshot.sv
module rcu_snapshot #(
  parameter int CNT_W    = 32,
  parameter int NUM_PINS = 4,
  parameter int SEL_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] rise,
  input  logic [NUM_PINS-1:0] fall,
  input  logic [SEL_W-1:0]    ref_sel,
  input  logic                ref_fall,
  input  logic                arm,
  input  logic [CNT_W-1:0]    ev_cnt,
  input  logic [CNT_W-1:0]    tm_cnt,
  input  logic                rd_clr,
  output logic [CNT_W-1:0]    snap_ev,
  output logic [CNT_W-1:0]    snap_tm,
  output logic                ready,
  output logic                cap_fire
);
  import rcu_pkg::*;

  logic ref_hit;
  assign ref_hit  = pick_edge(rise[ref_sel], fall[ref_sel], ref_fall);
  assign cap_fire = arm & ref_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_ev <= '0;
      snap_tm <= '0;
      ready   <= 1'b0;
    end else begin
      if (cap_fire) begin
        snap_ev <= ev_cnt;
        snap_tm <= tm_cnt;
      end
      if (cap_fire)    ready <= 1'b1;
      else if (rd_clr) ready <= 1'b0;
    end
  end

  // R4: both counters latched in the same cycle
  a_r4_pair: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> (snap_ev == $past(ev_cnt)) && (snap_tm == $past(tm_cnt)));
  // R6: flag sets on capture, clears on read without capture
  a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> ready);
  a_r6_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !cap_fire) |=> !ready);
  // R7: disarmed snapshot is frozen
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> $stable(snap_ev) && $stable(snap_tm) && ($past(ready) || !ready));
  // R8: flag survives overwrite while no read happens
  a_r8_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !rd_clr) |=> ready);
endmodule

// File: rtl/recip_capture_unit.sv
module recip_capture_unit #(
  parameter int CNT_W    = 32,
  parameter int NUM_PINS = 4,
  localparam int SEL_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_in,
  input  logic                csr_we,
  input  logic                csr_re,
  input  logic [1:0]          csr_addr,
  input  logic [31:0]         csr_wdata,
  output logic [31:0]         csr_rdata,
  output logic                cap_ready
);
  import rcu_pkg::*;

  // control fields
  logic             arm_q, ev_pin_q, ev_fall_q, tm_pin_q, tm_fall_q, rf_fall_q;
  logic [SEL_W-1:0] ev_sel_q, tm_sel_q, rf_sel_q;

  logic ctrl_wr;
  assign ctrl_wr = csr_we && (csr_addr == REG_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q     <= 1'b0;
      ev_pin_q  <= 1'b0;
      ev_fall_q <= 1'b0;
      tm_pin_q  <= 1'b0;
      tm_fall_q <= 1'b0;
      rf_fall_q <= 1'b0;
      ev_sel_q  <= '0;
      tm_sel_q  <= '0;
      rf_sel_q  <= '0;
    end else if (ctrl_wr) begin
      arm_q     <= csr_wdata[CB_ARM];
      ev_pin_q  <= csr_wdata[CB_EV_PIN];
      ev_fall_q <= csr_wdata[CB_EV_FALL];
      tm_pin_q  <= csr_wdata[CB_TM_PIN];
      tm_fall_q <= csr_wdata[CB_TM_FALL];
      rf_fall_q <= csr_wdata[CB_RF_FALL];
      ev_sel_q  <= csr_wdata[CB_EV_SEL +: SEL_W];
      tm_sel_q  <= csr_wdata[CB_TM_SEL +: SEL_W];
      rf_sel_q  <= csr_wdata[CB_RF_SEL +: SEL_W];
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^csr_wdata;

  // synchronized edges
  logic [NUM_PINS-1:0] rise, fall;
  rcu_pin_sync #(.NUM_PINS(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pins_in(pins_in), .rise(rise), .fall(fall));

  // two counters
  logic             ev_tick, tm_tick;
  logic [CNT_W-1:0] ev_cnt, tm_cnt;

  rcu_counter #(.CNT_W(CNT_W), .NUM_PINS(NUM_PINS), .SEL_W(SEL_W)) u_ev_cnt (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
    .src_pin(ev_pin_q), .fall_sel(ev_fall_q), .pin_sel(ev_sel_q),
    .tick(ev_tick), .count(ev_cnt));

  rcu_counter #(.CNT_W(CNT_W), .NUM_PINS(NUM_PINS), .SEL_W(SEL_W)) u_tm_cnt (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
    .src_pin(tm_pin_q), .fall_sel(tm_fall_q), .pin_sel(tm_sel_q),
    .tick(tm_tick), .count(tm_cnt));

  // snapshot pair
  logic             rd_clr, cap_fire;
  logic [CNT_W-1:0] snap_ev, snap_tm;
  assign rd_clr = csr_re && ((csr_addr == REG_SNAP_E) || (csr_addr == REG_SNAP_T));

  rcu_snapshot #(.CNT_W(CNT_W), .NUM_PINS(NUM_PINS), .SEL_W(SEL_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
    .ref_sel(rf_sel_q), .ref_fall(rf_fall_q), .arm(arm_q),
    .ev_cnt(ev_cnt), .tm_cnt(tm_cnt), .rd_clr(rd_clr),
    .snap_ev(snap_ev), .snap_tm(snap_tm), .ready(cap_ready),
    .cap_fire(cap_fire));

  // read path
  ctrl_view_t ctrl_view;
  always_comb begin
    ctrl_view         = '0;
    ctrl_view.arm     = arm_q;
    ctrl_view.ev_pin  = ev_pin_q;
    ctrl_view.ev_fall = ev_fall_q;
    ctrl_view.tm_pin  = tm_pin_q;
    ctrl_view.tm_fall = tm_fall_q;
    ctrl_view.rf_fall = rf_fall_q;
    ctrl_view.ev_sel  = 8'(ev_sel_q);
    ctrl_view.tm_sel  = 8'(tm_sel_q);
    ctrl_view.rf_sel  = 8'(rf_sel_q);
  end

  always_comb begin
    case (reg_addr_e'(csr_addr))
      REG_CTRL:   csr_rdata = ctrl_view;
      REG_STAT:   csr_rdata = CSR_W'(cap_ready);
      REG_SNAP_E: csr_rdata = CSR_W'(snap_ev);
      REG_SNAP_T: csr_rdata = CSR_W'(snap_tm);
      default:    csr_rdata = '0;
    endcase
  end

  // R5: capture and reads never restart the time counter on the system clock
  a_r5_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (tm_tick && (cap_fire || rd_clr)) |=> tm_cnt != '0 || $past(tm_cnt) == {CNT_W{1'b1}});
  // R10: a control write takes effect on the next cycle
  a_r10_arm_wr: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> arm_q == $past(csr_wdata[CB_ARM]));
endmodule

// File: tb/recip_capture_unit_tb_top.sv
module recip_capture_unit_tb_top;
  localparam int CW = 8;
  localparam int NP = 4;
  localparam logic [31:0] EN = 32'h1, EVP = 32'h2, EVF = 32'h4,
                          TMP = 32'h8, RFF = 32'h20;
  localparam logic [31:0] REF2 = 32'd2 << 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins_in = '0;
  logic          csr_we = 1'b0, csr_re = 1'b0;
  logic [1:0]    csr_addr = '0;
  logic [31:0]   csr_wdata = '0;
  logic [31:0]   csr_rdata;
  logic          cap_ready;

  int total = 0, bad = 0, cyc = 0;
  logic [7:0] off;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  recip_capture_unit #(.CNT_W(CW), .NUM_PINS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .pins_in(pins_in), .csr_we(csr_we),
    .csr_re(csr_re), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .cap_ready(cap_ready));

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk); csr_we = 1'b1; csr_addr = 2'd0; csr_wdata = v;
    @(negedge clk); csr_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); csr_addr = a; csr_re = 1'b1; #1 v = csr_rdata;
    @(negedge clk); csr_re = 1'b0;
  endtask

  task automatic ref_pulse(output int at);
    @(negedge clk); pins_in[2] = 1'b1; at = cyc;
    repeat (3) @(negedge clk); pins_in[2] = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pin_pulses(input int p, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); pins_in[p] = 1'b1;
      repeat (2) @(negedge clk); pins_in[p] = 1'b0;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check(v == 0, "R1 reset register", v, 0);
    end
    check(cap_ready == 1'b0, "R1 reset flag", 32'(cap_ready), 0);
  endtask

  task automatic t_both_sysclk;
    logic [31:0] e, t; int at;
    wr(EN | REF2);
    ref_pulse(at);
    check(cap_ready == 1'b1, "R6 flag set", 32'(cap_ready), 1);
    rd(2'd2, e); rd(2'd3, t);
    check(e == t, "R2 equal sysclk pair", e, t);
    check(cap_ready == 1'b0, "R6 flag cleared by read", 32'(cap_ready), 0);
    off = 8'(t) - 8'(at);
  endtask

  task automatic t_wrap;
    logic [31:0] ta, tb; int a, b;
    ref_pulse(a); rd(2'd3, ta);
    repeat (300) @(negedge clk);
    ref_pulse(b); rd(2'd3, tb);
    check(8'(tb - ta) == 8'(b - a), "R9 wrapped delta", 32'(8'(tb - ta)), 32'(8'(b - a)));
    check(8'(tb) == 8'(b) + off, "R4 latched value", tb, 32'(8'(b) + off));
  endtask

  task automatic t_ev_rise;
    logic [31:0] ea, eb, ec, ta, tb; int a, b, c;
    wr(EN | REF2 | EVP);
    ref_pulse(a); rd(2'd2, ea); rd(2'd3, ta);
    pin_pulses(0, 13);
    ref_pulse(b); rd(2'd2, eb); rd(2'd3, tb);
    check(8'(eb - ea) == 8'd13, "R3 rising event count", 32'(8'(eb - ea)), 13);
    check(8'(tb - ta) == 8'(b - a), "R5 gapless time delta", 32'(8'(tb - ta)), 32'(8'(b - a)));
    pin_pulses(0, 9);
    ref_pulse(c); rd(2'd2, ec);
    check(8'(ec - eb) == 8'd9, "R5 gapless event delta", 32'(8'(ec - eb)), 9);
  endtask

  task automatic t_ev_fall;
    logic [31:0] ea, eb; int a, b;
    wr(EN | REF2 | EVP | EVF);
    ref_pulse(a); rd(2'd2, ea);
    pin_pulses(0, 6);
    @(negedge clk); pins_in[0] = 1'b1;
    repeat (4) @(negedge clk);
    ref_pulse(b); rd(2'd2, eb);
    check(8'(eb - ea) == 8'd6, "R3 falling event count", 32'(8'(eb - ea)), 6);
    @(negedge clk); pins_in[0] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_ref_fall;
    logic [31:0] v; int f;
    wr(EN | REF2 | RFF);
    rd(2'd2, v);
    @(negedge clk); pins_in[2] = 1'b1;
    repeat (6) @(negedge clk);
    check(cap_ready == 1'b0, "R4 no capture on rise in falling mode", 32'(cap_ready), 0);
    pins_in[2] = 1'b0; f = cyc;
    repeat (4) @(negedge clk);
    check(cap_ready == 1'b1, "R4 capture on fall", 32'(cap_ready), 1);
    rd(2'd3, v);
    check(8'(v) == 8'(f) + off, "R4 falling latch value", v, 32'(8'(f) + off));
  endtask

  task automatic t_overwrite;
    logic [31:0] v; int a, b;
    wr(EN | REF2);
    rd(2'd2, v);
    ref_pulse(a);
    repeat (5) @(negedge clk);
    ref_pulse(b);
    check(cap_ready == 1'b1, "R8 flag stays set", 32'(cap_ready), 1);
    rd(2'd3, v);
    check(8'(v) == 8'(b) + off, "R8 newest edge kept", v, 32'(8'(b) + off));
  endtask

  task automatic t_disable;
    logic [31:0] e0, t0, e1, t1, c; int a;
    wr(REF2 | (32'd1 << 16) | RFF | EVF | 32'h80);
    rd(2'd0, c);
    check(c == (REF2 | (32'd1 << 16) | RFF | EVF), "R10 control readback", c,
          REF2 | (32'd1 << 16) | RFF | EVF);
    wr(REF2);
    rd(2'd2, e0); rd(2'd3, t0);
    ref_pulse(a);
    check(cap_ready == 1'b0, "R7 flag unchanged while disarmed", 32'(cap_ready), 0);
    rd(2'd2, e1); rd(2'd3, t1);
    check(e1 == e0, "R7 event snapshot frozen", e1, e0);
    check(t1 == t0, "R7 time snapshot frozen", t1, t0);
  endtask

  task automatic t_tm_pin;
    logic [31:0] ea, eb, ta, tb; int a, b;
    wr(EN | REF2 | TMP | (32'd1 << 16));
    ref_pulse(a); rd(2'd2, ea); rd(2'd3, ta);
    pin_pulses(0, 5);
    pin_pulses(1, 7);
    ref_pulse(b); rd(2'd2, eb); rd(2'd3, tb);
    check(8'(tb - ta) == 8'd7, "R3 time counter on pin 1 only", 32'(8'(tb - ta)), 7);
    check(8'(eb - ea) == 8'(b - a), "R2 event on sysclk", 32'(8'(eb - ea)), 32'(8'(b - a)));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_both_sysclk();
    t_wrap();
    t_ev_rise();
    t_ev_fall();
    t_ref_fall();
    t_overwrite();
    t_disable();
    t_tm_pin();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule